// File: doc/BRIEF.md
# Chip-Select Gated Registered Buffer

This block is a bank of clocked registers that sits between a memory controller's address and command lines and the devices behind it. On each rising clock edge, a vector of data lanes is captured into the data outputs, but only while at least one of two active-low chip-select inputs is low. When both selects are high, the data lanes keep their previous contents, which reduces switching on a deselected bus.

Three side-band lanes are registered on every rising edge, whatever the selects are doing. These are a copy of the primary chip select, an on-die-termination enable and a clock-enable. An active-low reset clears every output at once. Reset release passes through a short synchronizer, so the first capture after reset is a clean, whole-word capture on a known edge. The lanes are plain level signals with no flow control, so the block has no valid/ready handshake and never applies back-pressure.

Top module: `cs_gated_regbuf`

## Requirements
- R1: On a rising edge with `sel_pri_n` low, `q_out` takes `d_in`, whatever the level of `sel_sec_n`.
- R2: On a rising edge with `sel_pri_n` high and `sel_sec_n` low, `q_out` takes `d_in`.
- R3: On a rising edge with both `sel_pri_n` and `sel_sec_n` high, `q_out` keeps its previous value.
- R4: `sel_copy_out` takes `sel_pri_n` on every rising edge, including edges where both selects are high.
- R5: `odt_out` and `cke_out` take `odt_in` and `cke_in` on every rising edge, independent of both selects.
- R6: Between rising edges, every output holds its value, even when inputs change.
- R7: While `rst_n` is low, `q_out`, `sel_copy_out`, `odt_out` and `cke_out` are all low. The clear takes effect without waiting for a clock edge, and all other inputs are ignored.
- R8: Reset release is synchronized through `SYNC_STAGES` flops (default 2). With the default, the first capture after `rst_n` rises happens on the third rising edge, and outputs stay low on the first two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge capture clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| d_in | input | LANES (25) | Address/command data lanes |
| sel_pri_n | input | 1 | Primary chip select, active low |
| sel_sec_n | input | 1 | Secondary chip select, active low |
| odt_in | input | 1 | On-die-termination enable in |
| cke_in | input | 1 | Clock-enable in |
| q_out | output | LANES (25) | Registered data lanes |
| sel_copy_out | output | 1 | Registered copy of the primary select |
| odt_out | output | 1 | Registered termination enable |
| cke_out | output | 1 | Registered clock-enable |

## Verification
On every cycle out of reset, the embedded assertions check the following:
- Each edge with a select low loads the data lanes.
- Each edge with both selects high leaves the data lanes unchanged.
- The side-band lanes follow their inputs one edge later.
- The outputs are zero on any edge where reset is low.

Other behaviours can only be shown by the bench's scenarios. These are the exact edge count of the synchronized release, the clear taking effect between clock edges, and outputs staying still when inputs move mid-cycle.

// File: rtl/crb_pkg.sv
package crb_pkg;
  typedef struct packed {
    logic sel_copy;
    logic odt;
    logic cke;
  } side_t;
  localparam int SIDE_W = $bits(side_t);
endpackage

// File: rtl/crb_rst_sync.sv
module crb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      chain <= '0;
    end else begin
      chain[0] <= 1'b1;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign rst_n_sync = chain[STAGES-1];
endmodule

// File: rtl/crb_lane_bank.sv
module crb_lane_bank #(
  parameter int LANES = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LANES-1:0] d,
  output logic [LANES-1:0] q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q[g] <= 1'b0;
      else if (load) q[g] <= d[g];
    end
  end

  // R1 R2
  lane_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d)));
  // R3
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/crb_side_reg.sv
module crb_side_reg
  import crb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  side_t side_d,
  output side_t side_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) side_q <= '0;
    else        side_q <= side_d;
  end

  // R4 R5
  side_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (side_q == $past(side_d)));
endmodule

// File: rtl/cs_gated_regbuf.sv
module cs_gated_regbuf
  import crb_pkg::*;
#(
  parameter int LANES       = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] d_in,
  input  logic             sel_pri_n,
  input  logic             sel_sec_n,
  input  logic             odt_in,
  input  logic             cke_in,
  output logic [LANES-1:0] q_out,
  output logic             sel_copy_out,
  output logic             odt_out,
  output logic             cke_out
);
  logic  rst_n_int;
  logic  lane_load;
  side_t side_d, side_q;

  crb_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_int)
  );

  assign lane_load = !(sel_pri_n && sel_sec_n);

  crb_lane_bank #(.LANES(LANES)) u_lanes (
    .clk(clk), .rst_n(rst_n_int), .load(lane_load), .d(d_in), .q(q_out)
  );

  assign side_d = '{sel_copy: sel_pri_n, odt: odt_in, cke: cke_in};

  crb_side_reg u_side (
    .clk(clk), .rst_n(rst_n_int), .side_d(side_d), .side_q(side_q)
  );

  assign sel_copy_out = side_q.sel_copy;
  assign odt_out      = side_q.odt;
  assign cke_out      = side_q.cke;

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (q_out == '0 && !sel_copy_out && !odt_out && !cke_out));
endmodule

// File: tb/sim_cs_gated_regbuf.sv
`timescale 1ns/1ps
module sim_cs_gated_regbuf;
  localparam int W = 25;
  localparam int STG = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] d_in = '0;
  logic sel_pri_n = 1'b1, sel_sec_n = 1'b1, odt_in = 1'b0, cke_in = 1'b0;
  logic [W-1:0] q_out;
  logic sel_copy_out, odt_out, cke_out;

  int errors = 0, checks = 0;
  string req = "R7";
  bit cmp_en = 1'b1;

  // reference model
  logic [W-1:0] m_q = '0;
  logic m_cs = 0, m_odt = 0, m_cke = 0;
  int rel = 0;

  always #2.5 clk = ~clk;

  cs_gated_regbuf #(.LANES(W), .SYNC_STAGES(STG)) u0 (
    .clk(clk), .rst_n(rst_n), .d_in(d_in), .sel_pri_n(sel_pri_n),
    .sel_sec_n(sel_sec_n), .odt_in(odt_in), .cke_in(cke_in),
    .q_out(q_out), .sel_copy_out(sel_copy_out), .odt_out(odt_out),
    .cke_out(cke_out));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q = '0; m_cs = 0; m_odt = 0; m_cke = 0; rel = 0;
    end else if (rel < STG) begin
      rel++;
    end else begin
      if (!sel_pri_n || !sel_sec_n) m_q = d_in;
      m_cs = sel_pri_n; m_odt = odt_in; m_cke = cke_in;
    end
  end

  task automatic chk(string r, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", r, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(string r);
    chk(r, "q_out", q_out, m_q);
    chk(r, "sel_copy_out", W'(sel_copy_out), W'(m_cs));
    chk(r, "odt_out", W'(odt_out), W'(m_odt));
    chk(r, "cke_out", W'(cke_out), W'(m_cke));
  endtask

  // compared on every clock, away from the edge
  always @(negedge clk) if (cmp_en) compare_all(req);

  task automatic drive(logic pa, logic sb);
    @(negedge clk);
    #0.2;
    d_in = W'($urandom); sel_pri_n = pa; sel_sec_n = sb;
    odt_in = 1'($urandom); cke_in = 1'($urandom);
  endtask

  initial begin
    // R7: inputs ignored while reset low
    req = "R7";
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b0);
    // R8: release, outputs stay low for two edges, capture on third
    @(negedge clk); #0.2;
    d_in = 25'h1A5A5A5; sel_pri_n = 0; sel_sec_n = 1; odt_in = 1; cke_in = 1;
    rst_n = 1'b1;
    req = "R8";
    @(posedge clk); @(negedge clk); chk("R8", "q after edge1", q_out, '0);
    @(posedge clk); @(negedge clk); chk("R8", "q after edge2", q_out, '0);
    @(posedge clk); @(negedge clk); chk("R8", "q after edge3", q_out, 25'h1A5A5A5);
    req = "R1";
    for (int i = 0; i < 10; i++) drive(1'b0, 1'($urandom));
    req = "R2";
    for (int i = 0; i < 10; i++) drive(1'b1, 1'b0);
    req = "R3";
    for (int i = 0; i < 10; i++) drive(1'b1, 1'b1);
    req = "R4";
    for (int i = 0; i < 10; i++) drive(1'($urandom), 1'b1);
    req = "R5";
    for (int i = 0; i < 20; i++) drive(1'($urandom), 1'($urandom));
    // R6: input changes mid-cycle leave outputs unchanged
    req = "R6";
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      d_in = ~d_in; sel_pri_n = 0; odt_in = ~odt_in; cke_in = ~cke_in;
      #1 compare_all("R6");
      d_in = W'($urandom);
    end
    // R7: asynchronous clear mid-cycle
    drive(1'b0, 1'b0);
    @(posedge clk); #0.5;
    rst_n = 1'b0;
    #0.3;
    chk("R7", "q async", q_out, '0);
    chk("R7", "side async", W'({sel_copy_out, odt_out, cke_out}), '0);
    req = "R7";
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b0);
    rst_n = 1'b1;
    req = "R8";
    for (int i = 0; i < 6; i++) drive(1'($urandom), 1'($urandom));
    cmp_en = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule